// File: doc/BRIEF.md
# Stochastic Outer-Product Weight Updater

This block turns a row vector and a column error vector into per-crosspoint weight increments for a small resistive array, using random pulse coincidence in place of a multiplier. Each element arrives as an unsigned magnitude plus a sign bit. Each row and each column has its own linear feedback shift register (LFSR). In every update cycle, a stream emits a pulse when its LFSR value is below its magnitude. As a result, the fraction of cycles with a pulse follows the magnitude. A crosspoint counts the cycles in which its row pulse and its column pulse are both high.

Signs are handled by running the burst once per sign quadrant. In each pass, only the rows and columns whose signs match that quadrant are active. A coincidence moves the cell count up when the two quadrant signs agree and down when they differ. Each cell also reports, in every cycle, whether it is fully selected (both lines pulsing) or half selected (exactly one line pulsing). Only a full select changes the count.

An update is started with a one-cycle `start_i` and ends with a one-cycle `done_o`. The counts can be read until the next start.

Top module: `stoch_outer_updater`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low, every cell count is zero and every select flag is low.
- R2: A `start_i` seen while idle clears all counts, captures magnitudes, signs and burst length, and raises `busy_o` in the next cycle. While busy, `start_i`, `seed_i`, `bl_i` and the magnitude and sign inputs have no effect on flags or counts.
- R3: The burst length L is `bl_i` clamped to 1..MAX_BITS, with 0 read as 1. An update runs four passes of L cycles, so `busy_o` is high for 4L cycles. `done_o` is then high for exactly one cycle as `busy_o` falls.
- R4: Stream k (rows 0..ROWS-1, then columns as ROWS+c) is seeded with 1 + ((seed + 7k) mod (2^VAL_W − 1)). It advances once per busy cycle as a right-shifting Galois LFSR with tap mask 0xB8 for VAL_W=8, and it pulses when its state is less than its captured magnitude.
- R5: The passes run in the order (row +, col +), (row +, col −), (row −, col +), (row −, col −). A stream can pulse only in passes whose sign for its side equals its own sign bit (1 = negative).
- R6: Bit r·COLS+c of `full_sel_o` is the AND of row r and column c pulses. The same bit of `half_sel_o` is their XOR. Both are low when not busy.
- R7: In a full-select cycle the cell count steps by +1 if the pass signs agree and by −1 if they differ. The count is unchanged in half-select and unselected cycles.
- R8: Counts are two's complement of CNT_W bits at `cell_cnt_o[(r·COLS+c)·CNT_W +: CNT_W]`. They saturate at −2^(CNT_W−1) and 2^(CNT_W−1)−1 instead of wrapping.
- R9: A zero magnitude never pulses, so every cell on that row or column ends with count zero.
- R10: Over many seeds, the mean cell count for positive magnitudes a and b is within 0.5 of L·(a−1)(b−1)/(2^VAL_W−1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an update (taken only when idle) |
| seed_i | input | VAL_W | Seed base for all streams |
| bl_i | input | LEN_W | Requested pulses per pass |
| row_mag_i | input | ROWS·VAL_W | Row magnitudes, row r at [r·VAL_W +: VAL_W] |
| row_neg_i | input | ROWS | Row sign bits, 1 = negative |
| col_mag_i | input | COLS·VAL_W | Column magnitudes |
| col_neg_i | input | COLS | Column sign bits, 1 = negative |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle completion pulse |
| full_sel_o | output | ROWS·COLS | Per-cell full-select flag |
| half_sel_o | output | ROWS·COLS | Per-cell half-select flag |
| cell_cnt_o | output | ROWS·COLS·CNT_W | Per-cell signed increment counts |

## Verification
The bench runs its own LFSR reference model and compares every flag and count on every cycle. It therefore catches three kinds of error: a wrong quadrant order or sign rule, which would move counts the wrong way; a counter that moves on half selects, which would drift on cells with one idle line; and streams that do not reseed per update, which would make flags disagree from the first cycle.

Bursts with full-scale magnitudes drive cells into both saturation limits. A wrapping counter would come back with the opposite sign. Burst lengths of 0 and above the maximum check the clamp: a wrong clamp would stretch or shorten `busy_o` and misplace `done_o`.

A start pulse and new magnitudes applied mid-burst must leave the run untouched. A design that restarted or recaptured would diverge from the model. A sweep over 64 seeds confirms that the random streams give an unbiased mean product.

// File: rtl/stoch_upd_pkg.sv
package stoch_upd_pkg;

  // Pass order: bit 1 = row side negative, bit 0 = column side negative
  typedef enum logic [1:0] {
    PASS_PP = 2'b00,
    PASS_PN = 2'b01,
    PASS_NP = 2'b10,
    PASS_NN = 2'b11
  } pass_e;

  // Maximal-length Galois tap masks (right shift) for the supported widths
  function automatic logic [15:0] tap_mask(input int unsigned w);
    case (w)
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0E08;
      default: return 16'h00B8;
    endcase
  endfunction

  // Distinct nonzero seed per stream index
  function automatic int unsigned stream_seed(input int unsigned base,
                                              input int unsigned idx,
                                              input int unsigned w);
    int unsigned period;
    period = (32'd1 << w) - 32'd1;
    return 32'd1 + ((base + 32'd7 * idx) % period);
  endfunction

  // Burst length clamp: 0 -> 1, above the limit -> limit
  function automatic int unsigned clamp_len(input int unsigned bl,
                                            input int unsigned maxl);
    if (bl == 0) return 1;
    if (bl > maxl) return maxl;
    return bl;
  endfunction

  // Saturating signed step of +1 or -1 inside [lo, hi]
  function automatic int sat_step(input int v, input logic down,
                                  input int lo, input int hi);
    int n;
    n = down ? v - 1 : v + 1;
    if (n > hi) n = hi;
    if (n < lo) n = lo;
    return n;
  endfunction

endpackage

// File: rtl/su_stream.sv
module su_stream #(
  parameter int VAL_W = 8,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [VAL_W-1:0] seed,
  input  logic [VAL_W-1:0] mag,
  input  logic             en,
  output logic             pulse
);
  import stoch_upd_pkg::*;

  localparam logic [VAL_W-1:0] MASK = VAL_W'(tap_mask(VAL_W));

  logic [VAL_W-1:0] state_q;
  logic [VAL_W-1:0] state_nx;
  logic [VAL_W-1:0] seed_val;

  assign seed_val = VAL_W'(stream_seed(32'(seed), IDX, VAL_W));
  assign state_nx = (state_q >> 1) ^ (state_q[0] ? MASK : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= VAL_W'(1);
    else if (load)  state_q <= seed_val;
    else if (adv)   state_q <= state_nx;
  end

  assign pulse = en & (state_q < mag);

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> state_q != '0);

  // R9
  zero_mag_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == '0) |-> !pulse);

endmodule

// File: rtl/su_seq.sv
module su_seq #(
  parameter int MAX_BITS = 10,
  parameter int LEN_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] bl_i,
  output logic             load,
  output logic             busy,
  output logic             done,
  output logic [1:0]       pass
);
  import stoch_upd_pkg::*;

  logic             busy_q, done_q;
  logic [1:0]       pass_q;
  logic [LEN_W-1:0] step_q, len_q;
  logic             step_last;

  assign load      = start_i & ~busy_q;
  assign step_last = (step_q == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= PASS_PP;
      step_q <= '0;
      len_q  <= LEN_W'(1);
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        pass_q <= PASS_PP;
        step_q <= '0;
        len_q  <= LEN_W'(clamp_len(32'(bl_i), MAX_BITS));
      end else if (busy_q) begin
        if (step_last) begin
          step_q <= '0;
          if (pass_q == PASS_NN) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            pass_q <= pass_q + 2'd1;
          end
        end else begin
          step_q <= step_q + LEN_W'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign pass = pass_q;

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q && pass_q == PASS_PP && step_q == '0);

  // R3
  fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q < len_q) && (len_q != '0));

endmodule

// File: rtl/su_cell.sv
module su_cell #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             row_p,
  input  logic             col_p,
  input  logic             down,
  output logic             full,
  output logic             half,
  output logic [CNT_W-1:0] cnt
);
  import stoch_upd_pkg::*;

  localparam int HI = (1 << (CNT_W - 1)) - 1;
  localparam int LO = -(1 << (CNT_W - 1));

  logic [CNT_W-1:0] cnt_q;

  assign full = row_p & col_p;
  assign half = row_p ^ col_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (full)  cnt_q <= CNT_W'(sat_step(int'($signed(cnt_q)), down, LO, HI));
  end

  assign cnt = cnt_q;

  // R7
  half_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half |=> $stable(cnt_q));

  // R8
  top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'($signed(cnt_q)) == HI && full && !down) |=> int'($signed(cnt_q)) == HI);

  // R8
  bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'($signed(cnt_q)) == LO && full && down) |=> int'($signed(cnt_q)) == LO);

endmodule

// File: rtl/stoch_outer_updater.sv
module stoch_outer_updater #(
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int VAL_W    = 8,
  parameter int CNT_W    = 4,
  parameter int MAX_BITS = 10,
  parameter int LEN_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [VAL_W-1:0]         seed_i,
  input  logic [LEN_W-1:0]         bl_i,
  input  logic [ROWS*VAL_W-1:0]    row_mag_i,
  input  logic [ROWS-1:0]          row_neg_i,
  input  logic [COLS*VAL_W-1:0]    col_mag_i,
  input  logic [COLS-1:0]          col_neg_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [ROWS*COLS-1:0]     full_sel_o,
  output logic [ROWS*COLS-1:0]     half_sel_o,
  output logic [ROWS*COLS*CNT_W-1:0] cell_cnt_o
);

  localparam int CELLS = ROWS * COLS;

  logic                  load, busy;
  logic [1:0]            pass;
  logic                  pass_down;
  logic [ROWS*VAL_W-1:0] row_mag_q;
  logic [ROWS-1:0]       row_neg_q;
  logic [COLS*VAL_W-1:0] col_mag_q;
  logic [COLS-1:0]       col_neg_q;
  logic [ROWS-1:0]       row_p;
  logic [COLS-1:0]       col_p;

  su_seq #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bl_i(bl_i),
    .load(load), .busy(busy), .done(done_o), .pass(pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_mag_q <= '0;
      row_neg_q <= '0;
      col_mag_q <= '0;
      col_neg_q <= '0;
    end else if (load) begin
      row_mag_q <= row_mag_i;
      row_neg_q <= row_neg_i;
      col_mag_q <= col_mag_i;
      col_neg_q <= col_neg_i;
    end
  end

  assign pass_down = pass[1] ^ pass[0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    su_stream #(.VAL_W(VAL_W), .IDX(r)) u_rs (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(busy), .seed(seed_i),
      .mag(row_mag_q[r*VAL_W +: VAL_W]),
      .en(busy & (row_neg_q[r] == pass[1])),
      .pulse(row_p[r])
    );
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    su_stream #(.VAL_W(VAL_W), .IDX(ROWS + c)) u_cs (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(busy), .seed(seed_i),
      .mag(col_mag_q[c*VAL_W +: VAL_W]),
      .en(busy & (col_neg_q[c] == pass[0])),
      .pulse(col_p[c])
    );
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_cr
    for (genvar c = 0; c < COLS; c++) begin : g_cc
      su_cell #(.CNT_W(CNT_W)) u_cell (
        .clk(clk), .rst_n(rst_n), .clear(load),
        .row_p(row_p[r]), .col_p(col_p[c]), .down(pass_down),
        .full(full_sel_o[r*COLS + c]),
        .half(half_sel_o[r*COLS + c]),
        .cnt(cell_cnt_o[(r*COLS + c)*CNT_W +: CNT_W])
      );
    end
  end

  assign busy_o = busy;

  // R6
  sel_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (full_sel_o == '0) && (half_sel_o == '0));

  // R5
  row_sign_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (row_p & (row_neg_q ^ {ROWS{pass[1]}})) == '0);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cell_cnt_o == '0);

  // R6
  flag_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(full_sel_o) + $countones(half_sel_o) <= CELLS);

endmodule

// File: tb/stoch_outer_updater_tb.sv
module stoch_outer_updater_tb;
  localparam int ROWS = 4, COLS = 4, VAL_W = 8, CNT_W = 4, MAXB = 10, LEN_W = 4;
  localparam int PER = 255;
  localparam int HI = 7, LO = -8;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [VAL_W-1:0] seed_i = '0;
  logic [LEN_W-1:0] bl_i = '0;
  logic [ROWS*VAL_W-1:0] row_mag_i = '0;
  logic [ROWS-1:0] row_neg_i = '0;
  logic [COLS*VAL_W-1:0] col_mag_i = '0;
  logic [COLS-1:0] col_neg_i = '0;
  logic busy_o, done_o;
  logic [ROWS*COLS-1:0] full_sel_o, half_sel_o;
  logic [ROWS*COLS*CNT_W-1:0] cell_cnt_o;

  int checks = 0, failures = 0;
  int rm[ROWS], cm[COLS];
  bit rn[ROWS], cn[COLS];
  int st[ROWS+COLS];
  int mc[ROWS][COLS];

  always #10 clk = ~clk;

  stoch_outer_updater #(.ROWS(ROWS), .COLS(COLS), .VAL_W(VAL_W), .CNT_W(CNT_W),
    .MAX_BITS(MAXB), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i), .bl_i(bl_i),
    .row_mag_i(row_mag_i), .row_neg_i(row_neg_i), .col_mag_i(col_mag_i),
    .col_neg_i(col_neg_i), .busy_o(busy_o), .done_o(done_o),
    .full_sel_o(full_sel_o), .half_sel_o(half_sel_o), .cell_cnt_o(cell_cnt_o));

  function automatic int rd(int r, int c);
    int v;
    v = int'(cell_cnt_o[(r*COLS+c)*CNT_W +: CNT_W]);
    if (v > HI) v -= (1 << CNT_W);
    return v;
  endfunction

  function automatic int nxt(int s);
    if (s % 2 == 1) return (s / 2) ^ 184;
    return s / 2;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_vals();
    for (int r = 0; r < ROWS; r++) begin
      row_mag_i[r*VAL_W +: VAL_W] = VAL_W'(rm[r]);
      row_neg_i[r] = rn[r];
    end
    for (int c = 0; c < COLS; c++) begin
      col_mag_i[c*VAL_W +: VAL_W] = VAL_W'(cm[c]);
      col_neg_i[c] = cn[c];
    end
  endtask

  // Runs one update, comparing against the reference every cycle
  task automatic run(int seed, int bl, bit disturb);
    int len;
    @(negedge clk);
    seed_i = VAL_W'(seed);
    bl_i = LEN_W'(bl);
    drive_vals();
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    len = (bl == 0) ? 1 : (bl > MAXB ? MAXB : bl);
    for (int k = 0; k < ROWS+COLS; k++) st[k] = 1 + ((seed + 7*k) % PER);
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) mc[r][c] = 0;
    for (int q = 0; q < 4; q++) begin
      for (int s = 0; s < len; s++) begin
        bit rp[ROWS];
        bit cp[COLS];
        bit fbad, cbad;
        fbad = 0; cbad = 0;
        start_i = disturb && q == 1 && s == 0;
        if (start_i) begin
          seed_i = ~seed_i;
          bl_i = LEN_W'(3);
          row_mag_i = '0;
          col_neg_i = ~col_neg_i;
        end
        chk(busy_o == 1'b1, "R3", "busy during burst", int'(busy_o), 1);
        for (int r = 0; r < ROWS; r++) rp[r] = (int'(rn[r]) == q / 2) && st[r] < rm[r];
        for (int c = 0; c < COLS; c++) cp[c] = (int'(cn[c]) == q % 2) && st[ROWS+c] < cm[c];
        for (int r = 0; r < ROWS; r++) begin
          for (int c = 0; c < COLS; c++) begin
            bit ef, eh;
            ef = rp[r] & cp[c];
            eh = rp[r] ^ cp[c];
            if (full_sel_o[r*COLS+c] != ef || half_sel_o[r*COLS+c] != eh) begin
              fbad = 1;
              $display("FAIL R6 cell %0d,%0d pass %0d full/half actual=%0d expected=%0d",
                       r, c, q, {full_sel_o[r*COLS+c], half_sel_o[r*COLS+c]}, {ef, eh});
            end
            if (rd(r, c) != mc[r][c]) begin
              cbad = 1;
              $display("FAIL R7 cell %0d,%0d pass %0d count actual=%0d expected=%0d",
                       r, c, q, rd(r, c), mc[r][c]);
            end
          end
        end
        checks += 2;
        if (fbad) failures++;
        if (cbad) failures++;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++)
            if (rp[r] && cp[c]) begin
              int d;
              d = ((q / 2) != (q % 2)) ? -1 : 1;
              mc[r][c] = mc[r][c] + d;
              if (mc[r][c] > HI) mc[r][c] = HI;
              if (mc[r][c] < LO) mc[r][c] = LO;
            end
        for (int k = 0; k < ROWS+COLS; k++) st[k] = nxt(st[k]);
        @(negedge clk);
      end
    end
    start_i = 0;
    chk(done_o == 1'b1, "R3", "done after 4L cycles", int'(done_o), 1);
    chk(busy_o == 1'b0, "R3", "busy low at end", int'(busy_o), 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        chk(rd(r, c) == mc[r][c], "R7", "final count", rd(r, c), mc[r][c]);
    @(negedge clk);
    chk(done_o == 1'b0, "R3", "done one cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    real sum, mean, ideal;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && done_o == 0, "R1", "busy/done", int'({busy_o, done_o}), 0);
    chk(cell_cnt_o == '0, "R1", "counts", int'(cell_cnt_o != '0), 0);
    chk(full_sel_o == '0 && half_sel_o == '0, "R1", "flags", int'(full_sel_o | half_sel_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R5 R7 mixed signs, mid-range values
    rm = '{200, 90, 150, 30}; rn = '{0, 1, 0, 1};
    cm = '{120, 255, 60, 180}; cn = '{0, 0, 1, 1};
    run(17, 5, 0);

    // R2 mid-burst start and new inputs ignored
    run(101, 6, 1);

    // R3 clamps: 0 -> 1, 15 -> 10
    run(3, 0, 0);
    run(44, 15, 0);

    // R8 saturation at both limits
    rm = '{255, 255, 255, 255}; rn = '{0, 1, 0, 1};
    cm = '{255, 255, 255, 255}; cn = '{0, 0, 0, 0};
    run(9, 10, 0);
    chk(rd(0, 0) == HI, "R8", "upper saturation", rd(0, 0), HI);
    chk(rd(1, 0) == LO, "R8", "lower saturation", rd(1, 0), LO);

    // R9 zero magnitude row
    rm = '{255, 0, 128, 64}; rn = '{0, 0, 0, 0};
    cm = '{255, 200, 100, 50}; cn = '{0, 0, 0, 0};
    run(77, 10, 0);
    for (int c = 0; c < COLS; c++)
      chk(rd(1, c) == 0, "R9", "zero-magnitude row count", rd(1, c), 0);

    // R10 mean over many seeds
    rm = '{200, 200, 200, 200}; rn = '{0, 0, 0, 0};
    cm = '{128, 128, 128, 128}; cn = '{0, 0, 0, 0};
    sum = 0.0;
    for (int sd = 0; sd < 64; sd++) begin
      run(sd * 3 + 1, 10, 0);
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) sum += real'(rd(r, c));
    end
    mean = sum / real'(64 * ROWS * COLS);
    ideal = 10.0 * 199.0 * 127.0 / (255.0 * 255.0);
    checks++;
    if (mean < ideal - 0.5 || mean > ideal + 0.5) begin
      failures++;
      $display("FAIL R10 mean count actual=%0f expected=%0f", mean, ideal);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule